// File: doc/BRIEF.md
# Transmit Dominant Timeout Guard

This block sits between a protocol controller's transmit output and the enable of a differential bus driver. It watches the transmit data line, where low means dominant, and passes a dominant request to the driver only while a hardware timer says it is still plausible. A stuck-low transmit line, caused for example by a software hang or a broken trace, would otherwise hold the shared bus dominant and stop every other node from talking. The timer starts on a falling edge of the transmit line. If the line stays dominant for longer than the configured window, the guard turns the driver off and keeps it off until the line is seen recessive again.

The transmit input passes through a short synchronizer before the edge logic sees it. The guard is active only in normal mode. Leaving normal mode releases the driver and clears the guard's state. The timeout window is a parameter counted in clock cycles. Its default is 100000 cycles, which is 400 µs at 250 MHz and sits inside a 300 to 700 µs tolerance band.

Top module: `tx_dom_guard`

## Requirements
- R1: After reset, `drive_dom` and `timeout_flag` are 0, and the synchronizer holds recessive (1), so releasing reset with `tx_in` high produces no falling edge.
- R2: In normal mode, a falling edge on `tx_in` (1 to 0, where 0 is dominant) raises `drive_dom` three clock cycles after the input changes. When `tx_in` returns to 1, `drive_dom` drops two cycles after the input changes.
- R3: After a falling edge, `drive_dom` stays high for exactly `TIMEOUT_CYCLES` consecutive cycles if `tx_in` stays 0. In the next cycle `drive_dom` goes to 0 and `timeout_flag` goes to 1. The internal count never exceeds `TIMEOUT_CYCLES`.
- R4: Once tripped, the guard stays tripped while `tx_in` stays 0: `drive_dom` stays 0 and `timeout_flag` stays 1 for any further length of time.
- R5: A tripped guard clears when `tx_in` returns to 1. `timeout_flag` falls three cycles after the input changes, and a later falling edge drives dominant again.
- R6: Outside normal mode (`normal_mode` = 0), `drive_dom` and `timeout_flag` are 0 whatever `tx_in` does.
- R7: When `normal_mode` drops while the guard is driving or tripped, both outputs fall in that same cycle, and the guard returns to idle at the next clock edge.
- R8: If `tx_in` is already 0 when normal mode is entered, `drive_dom` stays 0 until `tx_in` has gone to 1 and then produced a fresh falling edge.
- R9: `timeout_flag` and `drive_dom` are never 1 in the same cycle.
- R10: Dominant pulses shorter than the window never trip the guard. Each new falling edge restarts the timer from zero, so back-to-back pulses do not add up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_in | input | 1 | Transmit data from the controller, 0 = dominant, 1 = recessive |
| normal_mode | input | 1 | High when the transceiver is in normal (driver-capable) mode |
| drive_dom | output | 1 | Gated request for the bus driver to drive dominant |
| timeout_flag | output | 1 | High while the driver is held off by an expired timeout |

## Verification
Some properties are checked on every cycle:
- The flag and the drive request are mutually exclusive.
- Both outputs are silent outside normal mode.
- The count never passes the limit and advances by one while running.
- An armed state follows every falling edge seen in normal mode.
- A tripped state holds while the line stays dominant and clears once it goes recessive.

Other behaviour only the directed scenarios can show:
- The exact cycle counts of the dominant window.
- The latency through the synchronizer.
- The refusal to drive from a stale dominant level on mode entry.
- The restart of the timer across back-to-back pulses.
- Recovery after a trip.

// File: rtl/tx_dom_guard_pkg.sv
package tx_dom_guard_pkg;

    typedef enum logic [1:0] {
        GRD_IDLE    = 2'd0,
        GRD_ARMED   = 2'd1,
        GRD_TRIPPED = 2'd2
    } grd_state_e;

    typedef struct packed {
        logic level; // synchronized line, 1 = recessive
        logic fall;  // recessive to dominant transition seen this cycle
    } tx_evt_t;

    function automatic int cnt_width(input int limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/tx_dom_sync.sv
module tx_dom_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b1;
                    else     chain[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b1;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/tx_dom_edge.sv
module tx_dom_edge
    import tx_dom_guard_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    line,
    output tx_evt_t evt
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= line;
    end

    always_comb begin
        evt.level = line;
        evt.fall  = prev_q & ~line;
    end
endmodule

// File: rtl/tx_dom_timer.sv
module tx_dom_timer
    import tx_dom_guard_pkg::*;
#(
    parameter int LIMIT = 100000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    output logic done
);
    localparam int W = cnt_width(LIMIT);
    localparam logic [W-1:0] LIM = W'(LIMIT);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr)               cnt_q <= '0;
        else if (en && cnt_q != LIM)  cnt_q <= cnt_q + 1'b1;
    end

    assign done = (cnt_q == LIM);

    // R3: the count saturates at the limit
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LIM);

    // R3: while running and below the limit the count steps by one
    p_step_r3: assert property (@(posedge clk) disable iff (rst)
        (en && !clr && !done) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/tx_dom_guard.sv
module tx_dom_guard
    import tx_dom_guard_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 100000,
    parameter int SYNC_STAGES    = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tx_in,
    input  logic normal_mode,
    output logic drive_dom,
    output logic timeout_flag
);
    logic       tx_sync;
    tx_evt_t    evt;
    grd_state_e state_q, state_n;
    logic       tmr_clr, tmr_en, tmr_done;

    tx_dom_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst(rst), .din(tx_in), .dout(tx_sync)
    );

    tx_dom_edge edge_i (
        .clk(clk), .rst(rst), .line(tx_sync), .evt(evt)
    );

    tx_dom_timer #(.LIMIT(TIMEOUT_CYCLES)) timer_i (
        .clk(clk), .rst(rst), .clr(tmr_clr), .en(tmr_en), .done(tmr_done)
    );

    always_comb begin
        state_n = state_q;
        if (!normal_mode) begin
            state_n = GRD_IDLE;
        end else begin
            case (state_q)
                GRD_IDLE:    if (evt.fall) state_n = GRD_ARMED;
                GRD_ARMED:   if (evt.level) state_n = GRD_IDLE;
                             else if (tmr_done) state_n = GRD_TRIPPED;
                GRD_TRIPPED: if (evt.level) state_n = GRD_IDLE;
                default:     state_n = GRD_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= GRD_IDLE;
        else     state_q <= state_n;
    end

    assign tmr_clr = (state_q != GRD_ARMED);
    assign tmr_en  = normal_mode && (state_q == GRD_ARMED) && !evt.level;

    assign drive_dom = normal_mode && (state_q == GRD_ARMED) && !evt.level && !tmr_done;
    assign timeout_flag = normal_mode &&
        ((state_q == GRD_TRIPPED) || ((state_q == GRD_ARMED) && tmr_done && !evt.level));

    // R9: suppression and driving exclude each other
    p_excl_r9: assert property (@(posedge clk) disable iff (rst)
        timeout_flag |-> !drive_dom);

    // R6: nothing leaves the guard outside normal mode
    p_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        !normal_mode |-> (!drive_dom && !timeout_flag));

    // R2: a falling edge in normal mode arms the timer
    p_arm_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == GRD_IDLE && normal_mode && evt.fall) |=> (state_q == GRD_ARMED));

    // R4: a trip holds while the line stays dominant
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == GRD_TRIPPED && normal_mode && !evt.level) |=> (state_q == GRD_TRIPPED));

    // R5: a recessive line clears the trip
    p_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == GRD_TRIPPED && evt.level) |=> (state_q == GRD_IDLE));

    // R7: leaving normal mode returns the guard to idle
    p_exit_r7: assert property (@(posedge clk) disable iff (rst)
        !normal_mode |=> (state_q == GRD_IDLE));
endmodule

// File: tb/tx_dom_guard_tb_top.sv
`timescale 1ns/1ps
module tx_dom_guard_tb_top;
    localparam int LIM = 40;

    logic clk = 1'b0;
    logic rst;
    logic tx_in;
    logic normal_mode;
    logic drive_dom;
    logic timeout_flag;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    tx_dom_guard #(.TIMEOUT_CYCLES(LIM), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst(rst), .tx_in(tx_in), .normal_mode(normal_mode),
        .drive_dom(drive_dom), .timeout_flag(timeout_flag)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic settle_idle();
        tx_in = 1'b1;
        normal_mode = 1'b1;
        tick(6);
    endtask

    task automatic t_reset();
        rst = 1'b1; tx_in = 1'b1; normal_mode = 1'b1;
        tick(3);
        chk("R1", "drive in reset", drive_dom, 1'b0);
        chk("R1", "flag in reset", timeout_flag, 1'b0);
        rst = 1'b0;
        tick(5);
        chk("R1", "drive after reset", drive_dom, 1'b0);
        chk("R1", "flag after reset", timeout_flag, 1'b0);
    endtask

    task automatic t_short_pulse();
        settle_idle();
        tx_in = 1'b0;
        tick(2);
        chk("R2", "drive before latency", drive_dom, 1'b0);
        tick(1);
        chk("R2", "drive after fall", drive_dom, 1'b1);
        tick(4);
        chk("R2", "drive mid pulse", drive_dom, 1'b1);
        tx_in = 1'b1;
        tick(1);
        chk("R2", "drive one cycle after release", drive_dom, 1'b1);
        tick(1);
        chk("R2", "drive after release", drive_dom, 1'b0);
        chk("R2", "flag after short pulse", timeout_flag, 1'b0);
    endtask

    task automatic t_timeout();
        int highs;
        settle_idle();
        tx_in = 1'b0;
        tick(3);
        highs = 0;
        for (int i = 0; i < LIM; i++) begin
            if (drive_dom === 1'b1) highs++;
            if (timeout_flag !== 1'b0) chk("R3", "flag early", timeout_flag, 1'b0);
            tick(1);
        end
        checks++;
        if (highs != LIM) begin
            errors++;
            $display("FAIL R3 dominant cycles: actual=%0d expected=%0d", highs, LIM);
        end
        chk("R3", "drive after window", drive_dom, 1'b0);
        chk("R3", "flag after window", timeout_flag, 1'b1);
        for (int i = 0; i < 3 * LIM; i++) begin
            tick(1);
            if (drive_dom !== 1'b0 || timeout_flag !== 1'b1) begin
                chk("R4", "tripped drive", drive_dom, 1'b0);
                chk("R4", "tripped flag", timeout_flag, 1'b1);
            end
        end
        chk("R4", "still tripped drive", drive_dom, 1'b0);
        chk("R4", "still tripped flag", timeout_flag, 1'b1);
        tx_in = 1'b1;
        tick(2);
        chk("R5", "flag before clear", timeout_flag, 1'b1);
        tick(1);
        chk("R5", "flag cleared", timeout_flag, 1'b0);
        chk("R5", "drive after clear", drive_dom, 1'b0);
        tick(3);
        tx_in = 1'b0;
        tick(3);
        chk("R5", "drive restored", drive_dom, 1'b1);
        tx_in = 1'b1;
        tick(4);
    endtask

    task automatic t_back_to_back();
        settle_idle();
        for (int p = 0; p < 3; p++) begin
            tx_in = 1'b0;
            tick(3);
            tick(LIM - 3);
            chk("R10", "drive near end of pulse", drive_dom, 1'b1);
            chk("R10", "flag during pulse", timeout_flag, 1'b0);
            tx_in = 1'b1;
            tick(3);
            chk("R10", "drive between pulses", drive_dom, 1'b0);
        end
        chk("R10", "flag after pulses", timeout_flag, 1'b0);
    endtask

    task automatic t_not_normal();
        settle_idle();
        normal_mode = 1'b0;
        tick(1);
        for (int i = 0; i < 2 * LIM; i++) begin
            tx_in = (i % 7) < 3;
            tick(1);
            if (drive_dom !== 1'b0 || timeout_flag !== 1'b0) begin
                chk("R6", "drive outside normal", drive_dom, 1'b0);
                chk("R6", "flag outside normal", timeout_flag, 1'b0);
            end
        end
        tx_in = 1'b0;
        tick(2 * LIM);
        chk("R6", "drive long low outside normal", drive_dom, 1'b0);
        chk("R6", "flag long low outside normal", timeout_flag, 1'b0);
    endtask

    task automatic t_stale_entry();
        normal_mode = 1'b0;
        tx_in = 1'b0;
        tick(6);
        normal_mode = 1'b1;
        tick(2 * LIM);
        chk("R8", "drive with stale low", drive_dom, 1'b0);
        chk("R8", "flag with stale low", timeout_flag, 1'b0);
        tx_in = 1'b1;
        tick(4);
        tx_in = 1'b0;
        tick(3);
        chk("R8", "drive after fresh fall", drive_dom, 1'b1);
        tx_in = 1'b1;
        tick(4);
    endtask

    task automatic t_exit_mode();
        settle_idle();
        tx_in = 1'b0;
        tick(5);
        chk("R7", "driving before exit", drive_dom, 1'b1);
        normal_mode = 1'b0;
        #0.5;
        chk("R7", "drive same cycle as exit", drive_dom, 1'b0);
        tick(3);
        normal_mode = 1'b1;
        tick(3);
        chk("R7", "no drive after re-entry", drive_dom, 1'b0);
        tx_in = 1'b1;
        tick(4);
        tx_in = 1'b0;
        tick(3 + LIM + 2);
        chk("R7", "tripped before exit", timeout_flag, 1'b1);
        normal_mode = 1'b0;
        #0.5;
        chk("R7", "flag same cycle as exit", timeout_flag, 1'b0);
        tick(2);
        normal_mode = 1'b1;
        tick(3);
        chk("R7", "flag after re-entry", timeout_flag, 1'b0);
        tx_in = 1'b1;
        tick(4);
    endtask

    initial begin
        t_reset();
        t_short_pulse();
        t_timeout();
        t_back_to_back();
        t_not_normal();
        t_stale_entry();
        t_exit_mode();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule